// File: doc/BRIEF.md
# Clock-Event Interrupt Flag Block with Security and Privilege Filtering

This block keeps six interrupt flags for clock events: the readiness of the two low-speed oscillators, of the two high-speed oscillators and of the PLL, plus a failure reported by the external high-speed clock monitor. A hardware event pulse sets its flag. Software clears a flag by writing a one to the matching bit of a write-one-to-clear register. A per-source enable turns a set flag into an interrupt output.

Each flag bit has its own security attribute, taken from a small configuration register. The external clock failure bit shares the attribute of the high-speed external ready bit. A non-secure access to a secure bit gets zero on a read, and a write to that bit has no effect. No error is reported. Two privilege controls can also restrict access to unprivileged accesses. One covers the secure bits and the other covers the non-secure bits. A blocked unprivileged access is silently masked in the same way.

The register bus is a single-cycle request interface. Each request carries an address, write data, a write strobe, a secure attribute and a privileged attribute. Read data is registered.

Top module: `clkirq_ctrl`

## Requirements
- R1: An `evt_i[i]` pulse sets flag i at the next clock edge. When a permitted clear of bit i lands in the same cycle as the pulse, the flag stays set.
- R2: A permitted write of 1 to bit i of the clear register (byte offset 0x08) clears flag i at the next edge. A 0 in bit i leaves flag i unchanged.
- R3: Bit order in the flag, enable and clear registers: 0 low-speed internal ready, 1 low-speed external ready, 2 high-speed internal ready, 3 high-speed external ready, 4 PLL ready, 5 external clock failure. Bit 5 takes its security attribute from group 3.
- R4: The security register (offset 0x0C) holds one secure bit per group in bits [4:0]. The privilege register (offset 0x10) holds secure-privilege in bit 0 and non-secure-privilege in bit 1. Both registers accept writes only from secure accesses, and only from privileged ones while secure-privilege is set. Any other access reads them as zero.
- R5: A non-secure access to a bit whose group is secure reads 0 in the flag register (offset 0x00) and in the enable register (offset 0x04). Its writes to that bit in the clear register and in the enable register are ignored.
- R6: While secure-privilege is set, unprivileged accesses to secure bits read 0 and their writes are ignored. While non-secure-privilege is set, the same holds for non-secure bits.
- R7: The clear register always reads as zero.
- R8: `irq_o[i]` is high while flag i and enable bit i are both set. It is low in the cycle after the edge that clears the flag or the enable.
- R9: After reset, all flags, enables, security bits and privilege bits are 0, and `irq_o` is 0.
- R10: Read data appears on `rdata_o` in the cycle after the read request and holds until the next read. An access to an unmapped offset (0x14 to 0x1C) or to a misaligned address reads 0, and a write there changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte address |
| wdata_i | input | 6 | Write data |
| sec_i | input | 1 | Access is secure |
| priv_i | input | 1 | Access is privileged |
| rdata_o | output | 6 | Registered read data |
| evt_i | input | 6 | Hardware set pulses, one per source |
| irq_o | output | 6 | Interrupt outputs, one per source |

## Verification
A hardware set pulse and a software clear can reach the same flag in the same cycle. The bench provokes this by raising `evt_i` for one source in the same cycle as a permitted clear write to that bit. It then reads the flag register and expects the bit to still be set, while a neighbouring bit cleared in the same write is expected to be clear. The security and privilege filters are judged the same way: a blocked access is issued, then a fully permitted secure, privileged read exposes the true flag state.

// File: rtl/clkirq_pkg.sv
package clkirq_pkg;

    localparam int NSRC   = 6;
    localparam int NGRP   = 5;
    localparam int ADDR_W = 5;
    localparam int IDX_W  = ADDR_W - 2;

    // Register index, taken from address bits [ADDR_W-1:2]
    localparam logic [IDX_W-1:0] REG_FLAG = 3'd0;
    localparam logic [IDX_W-1:0] REG_EN   = 3'd1;
    localparam logic [IDX_W-1:0] REG_CLR  = 3'd2;
    localparam logic [IDX_W-1:0] REG_SEC  = 3'd3;
    localparam logic [IDX_W-1:0] REG_PRIV = 3'd4;

    localparam logic [ADDR_W-1:0] ADDR_FLAG = {REG_FLAG, 2'b00};
    localparam logic [ADDR_W-1:0] ADDR_EN   = {REG_EN,   2'b00};
    localparam logic [ADDR_W-1:0] ADDR_CLR  = {REG_CLR,  2'b00};
    localparam logic [ADDR_W-1:0] ADDR_SEC  = {REG_SEC,  2'b00};
    localparam logic [ADDR_W-1:0] ADDR_PRIV = {REG_PRIV, 2'b00};

    // Security group of each source; the clock failure source shares group 3
    function automatic int grp_of(input int src);
        return (src == 5) ? 3 : src;
    endfunction

    typedef struct packed {
        logic [NSRC-1:0] en;
        logic [NGRP-1:0] sec;
        logic            spriv;
        logic            nspriv;
        logic [NSRC-1:0] rdata;
    } ctrl_s;

endpackage

// File: rtl/clkirq_access.sv
module clkirq_access
    import clkirq_pkg::*;
#(
    parameter int N_SRC = NSRC,
    parameter int N_GRP = NGRP
) (
    input  logic [N_GRP-1:0] sec_cfg_i,
    input  logic             spriv_i,
    input  logic             nspriv_i,
    input  logic             acc_sec_i,
    input  logic             acc_priv_i,
    output logic [N_SRC-1:0] allow_o
);

    logic secure_ok;
    logic nonsec_ok;

    // Permission for an access to a secure bit and to a non-secure bit
    always_comb begin
        secure_ok = acc_sec_i && (!spriv_i || acc_priv_i);
        nonsec_ok = !nspriv_i || acc_priv_i;
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        localparam int GRP = grp_of(i);
        always_comb begin
            allow_o[i] = sec_cfg_i[GRP] ? secure_ok : nonsec_ok;
        end
    end

endmodule

// File: rtl/clkirq_flags.sv
module clkirq_flags #(
    parameter int N_SRC = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_SRC-1:0] set_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] flag_o
);

    logic [N_SRC-1:0] flag_d, flag_q;

    // A set applied in the same cycle as a clear wins
    always_comb begin
        flag_d = (flag_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flag_q <= '0;
        else         flag_q <= flag_d;
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/clkirq_ctrl.sv
module clkirq_ctrl
    import clkirq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NSRC-1:0]   wdata_i,
    input  logic              sec_i,
    input  logic              priv_i,
    output logic [NSRC-1:0]   rdata_o,
    input  logic [NSRC-1:0]   evt_i,
    output logic [NSRC-1:0]   irq_o
);

    ctrl_s ctrl_d, ctrl_q;

    logic [NSRC-1:0]  allow_w;
    logic [NSRC-1:0]  flag_w;
    logic [NSRC-1:0]  clr_w;
    logic [IDX_W-1:0] idx;
    logic             aligned;
    logic             cfg_ok;

    clkirq_access #(.N_SRC(NSRC), .N_GRP(NGRP)) u_access (
        .sec_cfg_i  (ctrl_q.sec),
        .spriv_i    (ctrl_q.spriv),
        .nspriv_i   (ctrl_q.nspriv),
        .acc_sec_i  (sec_i),
        .acc_priv_i (priv_i),
        .allow_o    (allow_w)
    );

    clkirq_flags #(.N_SRC(NSRC)) u_flags (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (evt_i),
        .clr_i  (clr_w),
        .flag_o (flag_w)
    );

    always_comb begin
        ctrl_d  = ctrl_q;
        clr_w   = '0;
        idx     = addr_i[ADDR_W-1:2];
        aligned = (addr_i[1:0] == 2'b00);
        // The configuration registers need a secure access, privileged while spriv is set
        cfg_ok  = sec_i && (!ctrl_q.spriv || priv_i);

        if (req_i && we_i && aligned) begin
            case (idx)
                REG_EN:   ctrl_d.en = (ctrl_q.en & ~allow_w) | (wdata_i & allow_w);
                REG_CLR:  clr_w = wdata_i & allow_w;
                REG_SEC:  if (cfg_ok) ctrl_d.sec = wdata_i[NGRP-1:0];
                REG_PRIV: if (cfg_ok) begin
                    ctrl_d.spriv  = wdata_i[0];
                    ctrl_d.nspriv = wdata_i[1];
                end
                default: ;
            endcase
        end

        if (req_i && !we_i) begin
            ctrl_d.rdata = '0;
            if (aligned) begin
                case (idx)
                    REG_FLAG: ctrl_d.rdata = flag_w & allow_w;
                    REG_EN:   ctrl_d.rdata = ctrl_q.en & allow_w;
                    REG_SEC:  if (cfg_ok) ctrl_d.rdata = {{(NSRC-NGRP){1'b0}}, ctrl_q.sec};
                    REG_PRIV: if (cfg_ok) ctrl_d.rdata = {{(NSRC-2){1'b0}}, ctrl_q.nspriv, ctrl_q.spriv};
                    default:  ctrl_d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctrl_q <= '0;
        else         ctrl_q <= ctrl_d;
    end

    assign rdata_o = ctrl_q.rdata;
    assign irq_o   = flag_w & ctrl_q.en;

endmodule

// File: rtl/clkirq_ctrl_chk.sv
module clkirq_ctrl_chk
    import clkirq_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_i,
    input logic              we_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [NSRC-1:0]   wdata_i,
    input logic              sec_i,
    input logic [NSRC-1:0]   evt_i,
    input logic [NSRC-1:0]   irq_o,
    input logic [NSRC-1:0]   rdata_o,
    input logic [NSRC-1:0]   flag,
    input logic [NSRC-1:0]   allow,
    input logic [NGRP-1:0]   sec_cfg
);

    logic clr_wr;
    logic clr_rd;
    assign clr_wr = req_i && we_i  && (addr_i == ADDR_CLR);
    assign clr_rd = req_i && !we_i && (addr_i == ADDR_CLR);

    // R7: the clear register reads as zero
    a_r7_clr_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_rd |=> (rdata_o == '0));

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        localparam int GRP = grp_of(i);

        // R1: an event always sets its flag, even against a clear
        a_r1_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
            evt_i[i] |=> flag[i]);

        // R2: a permitted write of one clears the flag
        a_r2_clear_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_wr && wdata_i[i] && allow[i] && !evt_i[i]) |=> !flag[i]);

        // R2: a zero bit leaves the flag alone
        a_r2_zero_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_wr && !wdata_i[i] && flag[i]) |=> flag[i]);

        // R5: a non-secure clear of a secure bit has no effect
        a_r5_ns_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_wr && !sec_i && sec_cfg[GRP] && flag[i]) |=> flag[i]);

        // R8: the interrupt drops in the cycle after a clear
        a_r8_irq_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_wr && wdata_i[i] && allow[i] && !evt_i[i]) |=> !irq_o[i]);
    end

endmodule

bind clkirq_ctrl clkirq_ctrl_chk u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .sec_i   (sec_i),
    .evt_i   (evt_i),
    .irq_o   (irq_o),
    .rdata_o (rdata_o),
    .flag    (flag_w),
    .allow   (allow_w),
    .sec_cfg (ctrl_q.sec)
);

// File: tb/tb_clkirq_ctrl.sv
module tb_clkirq_ctrl;
    import clkirq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0;
    logic              we = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [NSRC-1:0]   wdata = '0;
    logic              sec = 1'b0;
    logic              priv = 1'b0;
    logic [NSRC-1:0]   rdata;
    logic [NSRC-1:0]   evt = '0;
    logic [NSRC-1:0]   irq;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkirq_ctrl dut (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .sec_i(sec), .priv_i(priv), .rdata_o(rdata),
        .evt_i(evt), .irq_o(irq)
    );

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [NSRC-1:0] d, input logic s, input logic p);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = a; wdata = d; sec = s; priv = p;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic s, input logic p, output logic [NSRC-1:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = a; sec = s; priv = p;
        @(negedge clk);
        req = 1'b0;
        d = rdata;
    endtask

    task automatic pulse(input logic [NSRC-1:0] e);
        @(negedge clk);
        evt = e;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic t_reset;
        logic [NSRC-1:0] d;
        rd(ADDR_FLAG, 1'b1, 1'b1, d); chk("R9", "flags after reset", int'(d), 0);
        rd(ADDR_EN,   1'b1, 1'b1, d); chk("R9", "enables after reset", int'(d), 0);
        rd(ADDR_SEC,  1'b1, 1'b1, d); chk("R9", "security after reset", int'(d), 0);
        rd(ADDR_PRIV, 1'b1, 1'b1, d); chk("R9", "privilege after reset", int'(d), 0);
        chk("R9", "irq after reset", int'(irq), 0);
    endtask

    task automatic t_set_clear;
        logic [NSRC-1:0] d;
        pulse(6'h3F);
        rd(ADDR_FLAG, 1'b1, 1'b1, d); chk("R1", "all events set", int'(d), 'h3F);
        wr(ADDR_CLR, 6'h05, 1'b1, 1'b1);
        rd(ADDR_FLAG, 1'b1, 1'b1, d); chk("R2", "clear bits 0,2", int'(d), 'h3A);
        wr(ADDR_CLR, 6'h00, 1'b1, 1'b1);
        rd(ADDR_FLAG, 1'b1, 1'b1, d); chk("R2", "zero write keeps", int'(d), 'h3A);
    endtask

    task automatic t_irq;
        logic [NSRC-1:0] d;
        wr(ADDR_EN, 6'h3F, 1'b1, 1'b1);
        chk("R8", "irq follows flags", int'(irq), 'h3A);
        wr(ADDR_CLR, 6'h02, 1'b1, 1'b1);
        chk("R8", "irq low cycle after clear", int'(irq), 'h38);
        rd(ADDR_EN, 1'b1, 1'b1, d); chk("R8", "enable readback", int'(d), 'h3F);
        wr(ADDR_EN, 6'h08, 1'b1, 1'b1);
        chk("R8", "irq after disable", int'(irq), 'h08);
    endtask

    task automatic t_set_priority;
        logic [NSRC-1:0] d;
        @(negedge clk);
        evt = 6'h04;
        req = 1'b1; we = 1'b1; addr = ADDR_CLR; wdata = 6'h0C; sec = 1'b1; priv = 1'b1;
        @(negedge clk);
        evt = '0; req = 1'b0; we = 1'b0;
        // bit 2 set wins over clear, bit 3 cleared
        rd(ADDR_FLAG, 1'b1, 1'b1, d); chk("R1", "set beats clear", int'(d), 'h34);
        wr(ADDR_CLR, 6'h3F, 1'b1, 1'b1);
        rd(ADDR_FLAG, 1'b1, 1'b1, d); chk("R2", "clear all", int'(d), 0);
    endtask

    task automatic t_security;
        logic [NSRC-1:0] d;
        wr(ADDR_SEC, 6'h08, 1'b1, 1'b1);
        pulse(6'h3F);
        rd(ADDR_FLAG, 1'b0, 1'b1, d); chk("R3", "ns read masks bits 3 and 5", int'(d), 'h17);
        wr(ADDR_CLR, 6'h3F, 1'b0, 1'b1);
        rd(ADDR_FLAG, 1'b1, 1'b1, d); chk("R5", "ns clear spares secure bits", int'(d), 'h28);
        wr(ADDR_SEC, 6'h00, 1'b0, 1'b1);
        rd(ADDR_SEC, 1'b1, 1'b1, d); chk("R4", "ns write to security ignored", int'(d), 'h08);
        rd(ADDR_SEC, 1'b0, 1'b1, d); chk("R4", "ns read of security", int'(d), 0);
        rd(ADDR_EN, 1'b0, 1'b1, d); chk("R5", "ns read of secure enable", int'(d), 0);
        wr(ADDR_EN, 6'h3F, 1'b0, 1'b1);
        rd(ADDR_EN, 1'b1, 1'b1, d); chk("R5", "ns enable write partial", int'(d), 'h1F);
        chk("R8", "irq with secure flags", int'(irq), 'h08);
    endtask

    task automatic t_privilege;
        logic [NSRC-1:0] d;
        wr(ADDR_PRIV, 6'h01, 1'b1, 1'b1);
        pulse(6'h3F);
        rd(ADDR_FLAG, 1'b1, 1'b0, d); chk("R6", "unpriv secure read", int'(d), 'h17);
        wr(ADDR_CLR, 6'h3F, 1'b1, 1'b0);
        rd(ADDR_FLAG, 1'b1, 1'b1, d); chk("R6", "unpriv secure clear", int'(d), 'h28);
        wr(ADDR_SEC, 6'h00, 1'b1, 1'b0);
        rd(ADDR_SEC, 1'b1, 1'b1, d); chk("R4", "unpriv security write ignored", int'(d), 'h08);
        wr(ADDR_PRIV, 6'h02, 1'b1, 1'b1);
        rd(ADDR_PRIV, 1'b1, 1'b1, d); chk("R4", "privilege readback", int'(d), 'h02);
        rd(ADDR_FLAG, 1'b0, 1'b0, d); chk("R6", "unpriv ns read", int'(d), 0);
        pulse(6'h3F);
        wr(ADDR_CLR, 6'h3F, 1'b0, 1'b0);
        rd(ADDR_FLAG, 1'b1, 1'b1, d); chk("R6", "unpriv ns clear ignored", int'(d), 'h3F);
        wr(ADDR_CLR, 6'h3F, 1'b0, 1'b1);
        rd(ADDR_FLAG, 1'b1, 1'b1, d); chk("R6", "priv ns clear", int'(d), 'h28);
        rd(ADDR_FLAG, 1'b1, 1'b0, d); chk("R6", "unpriv secure read, spriv off", int'(d), 'h28);
    endtask

    task automatic t_misc;
        logic [NSRC-1:0] d;
        rd(ADDR_CLR, 1'b1, 1'b1, d); chk("R7", "clear register reads zero", int'(d), 0);
        rd(5'h14, 1'b1, 1'b1, d); chk("R10", "unmapped read", int'(d), 0);
        wr(5'h14, 6'h3F, 1'b1, 1'b1);
        wr(ADDR_CLR | 5'h01, 6'h3F, 1'b1, 1'b1);
        rd(ADDR_FLAG, 1'b1, 1'b1, d); chk("R10", "unmapped and misaligned writes", int'(d), 'h28);
        @(negedge clk);
        chk("R10", "read data held", int'(rdata), 'h28);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_set_clear();
        t_irq();
        t_set_priority();
        t_security();
        t_privilege();
        t_misc();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog: actual %0d expected below %0d cycles", WD_CYCLES, WD_CYCLES);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule